// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a group of output clocks that all share one source clock. An active-low stop request arrives from outside with no timing relation to that clock. The block passes the request through a synchronizer in the source clock domain. After a fixed latency it then stops the group or lets it run again. A stopped output is always held low. The gating enable changes only while the source clock is low, so every high phase on a gated output is either complete or absent.

Each instance sets its own stop latency, restart latency and minimum enabled interval. The same block can therefore drive a fast processor clock group with tight latencies and a long minimum run, or a bus clock group with a short minimum run. A stop request that arrives while the minimum run is still counting is held and applied as soon as the interval ends.

A companion output either runs freely or follows the gated group, as chosen by `free_sel`. A status flag shows whether the high phases of the group are currently being suppressed.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Rising edges of `clk_src` are numbered from E1, the first edge after `stop_n` falls. While the group is running and the minimum interval has been met, the gated outputs still deliver the high phases that start at edges E1 to E(STOP_LAT). From E(STOP_LAT+1) onward they stay low.
- R2: When `stop_n` rises while the group is stopped, the gated outputs stay low for the high phases that start at E1 to E(START_LAT). They deliver a high phase again from E(START_LAT+1) onward.
- R3: A gated output is low during a high phase of `clk_src` that is suppressed. A delivered high phase lasts for the whole high phase of `clk_src`: it is never cut short and never starts late.
- R4: After a restart, the group delivers at least MIN_ON high phases before it is stopped again. A stop request that arrives earlier is held. The stop then takes effect so that exactly MIN_ON high phases are delivered.
- R5: If `stop_n` returns low before the restart latency has run out, the group stays stopped and no high phase appears.
- R6: When `free_sel` is 0, `clk_free` follows `clk_src` and ignores the stop request.
- R7: When `free_sel` is 1, `clk_free` equals the gated outputs, including the stopped state.
- R8: All bits of `clk_gated` are identical at all times.
- R9: During each high phase of `clk_src`, `stopped` is 1 exactly when that high phase is suppressed on the gated outputs.
- R10: After reset the group is running with `stopped` at 0, and the minimum interval counts as already met, so a stop request takes effect with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock of the gated group |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_n | input | 1 | Asynchronous stop request, low to stop |
| free_sel | input | 1 | 0: companion output free-running; 1: companion output gated |
| clk_gated | output | NUM_GATED | Gated clock outputs |
| clk_free | output | 1 | Companion clock output |
| stopped | output | 1 | 1 while the group's high phases are suppressed |

## Verification
The bench builds the block with two gated outputs, a two-stage synchronizer, a stop latency of 3, a restart latency of 5 and a minimum run of 10 cycles. The two latencies differ, so a swap between the stop and restart counts shows up as an edge-count error. The short minimum run makes the held-stop case reachable within a few cycles of a restart, where exactly ten delivered high phases are expected. Randomly timed toggles of the stop request and of `free_sel` check the latency edges and the companion output repeatedly. A one-cycle release checks that an aborted restart leaves the group stopped.

// File: rtl/csc_pkg.sv
// Shared types and helpers for the clock stop controller.
// Assumes synchronizer depth of at least two stages.
package csc_pkg;

    // Gating state of the clock group.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } gate_st_e;

    // Cycles the controller waits after the synchronizer so that the total
    // latency equals the requested one (clamped at the structural minimum).
    function automatic int lat_extra(input int lat, input int sync_stages);
        return (lat > sync_stages + 1) ? lat - sync_stages - 1 : 0;
    endfunction

endpackage

// File: rtl/csc_sync.sv
// Multi-flop synchronizer bringing an asynchronous level into the clk domain.
// Assumes STAGES >= 2; the reset value matches the idle level of the input.
module csc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/csc_fsm.sv
// Decides on rising edges whether the clock group should run.
// Applies extra stop/start delays and a minimum enabled interval.
// Assumes MIN_ON >= 1; a stop pending during the minimum interval is held.
module csc_fsm
    import csc_pkg::*;
#(
    parameter int STOP_EXTRA  = 0,
    parameter int START_EXTRA = 0,
    parameter int MIN_ON      = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_stop,
    output logic run
);

    localparam int MSAT = MIN_ON - 1;
    localparam int MW   = $clog2(MIN_ON + 1);
    localparam int LMAX = (STOP_EXTRA > START_EXTRA) ? STOP_EXTRA : START_EXTRA;
    localparam int LW   = $clog2(LMAX + 2);
    localparam logic [LW-1:0] STOP_LIM  = LW'(STOP_EXTRA);
    localparam logic [LW-1:0] START_LIM = LW'(START_EXTRA);
    localparam logic [MW-1:0] MIN_LIM   = MW'(MSAT);

    gate_st_e        st_q;
    logic [LW-1:0]   lat_q;
    logic [MW-1:0]   on_q;
    logic            min_ok;

    assign min_ok = (on_q == MIN_LIM);

    // Running/halted decision with latency and minimum-run counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            lat_q <= '0;
            on_q  <= MIN_LIM;
        end else if (st_q == ST_RUN) begin
            if (!min_ok) on_q <= on_q + 1'b1;
            if (req_stop) begin
                if ((lat_q == STOP_LIM) && min_ok) begin
                    st_q  <= ST_HALT;
                    lat_q <= '0;
                end else if (lat_q != STOP_LIM) begin
                    lat_q <= lat_q + 1'b1;
                end
            end else begin
                lat_q <= '0;
            end
        end else begin
            if (!req_stop) begin
                if (lat_q == START_LIM) begin
                    st_q  <= ST_RUN;
                    lat_q <= '0;
                    on_q  <= '0;
                end else begin
                    lat_q <= lat_q + 1'b1;
                end
            end else begin
                lat_q <= '0;
            end
        end
    end

    assign run = (st_q == ST_RUN);

endmodule

// File: rtl/csc_gate.sv
// Glitch-free AND gating of the clock group and the companion output.
// The enable is retimed on the falling edge so it moves only while clk is low.
// Assumes free_sel is static or changes only while the group is running.
module csc_gate #(
    parameter int NUM_GATED = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 free_sel,
    output logic [NUM_GATED-1:0] clk_gated,
    output logic                 clk_free,
    output logic                 stopped
);

    logic en_q;
    logic gclk;

    // Retime the run decision into the low phase of the clock.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= run;
    end

    assign gclk = clk & en_q;

    for (genvar g = 0; g < NUM_GATED; g++) begin : g_out
        assign clk_gated[g] = gclk;
    end

    assign clk_free = free_sel ? gclk : clk;
    assign stopped  = ~en_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
// Top of the clock stop controller: synchronizer, decision logic and gate.
// Latencies are counted in source-clock rising edges from the first edge
// that samples the new stop_n level.
module clk_stop_ctrl
    import csc_pkg::*;
#(
    parameter int NUM_GATED   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int STOP_LAT    = 3,
    parameter int START_LAT   = 3,
    parameter int MIN_ON      = 100
) (
    input  logic                 clk_src,
    input  logic                 rst_n,
    input  logic                 stop_n,
    input  logic                 free_sel,
    output logic [NUM_GATED-1:0] clk_gated,
    output logic                 clk_free,
    output logic                 stopped
);

    localparam int STOP_X  = lat_extra(STOP_LAT, SYNC_STAGES);
    localparam int START_X = lat_extra(START_LAT, SYNC_STAGES);

    logic stop_sync_n;
    logic run;

    csc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .async_in (stop_n),
        .sync_out (stop_sync_n)
    );

    csc_fsm #(.STOP_EXTRA(STOP_X), .START_EXTRA(START_X), .MIN_ON(MIN_ON)) u_fsm (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .req_stop (~stop_sync_n),
        .run      (run)
    );

    csc_gate #(.NUM_GATED(NUM_GATED)) u_gate (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .run       (run),
        .free_sel  (free_sel),
        .clk_gated (clk_gated),
        .clk_free  (clk_free),
        .stopped   (stopped)
    );

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
// Checker for clk_stop_ctrl, sampled just before each falling edge
// (i.e. in the high phase of the source clock).
module clk_stop_ctrl_chk #(
    parameter int NUM_GATED = 2,
    parameter int MIN_ON    = 100
) (
    input logic                 clk_src,
    input logic                 rst_n,
    input logic                 free_sel,
    input logic [NUM_GATED-1:0] clk_gated,
    input logic                 clk_free,
    input logic                 stopped
);

    localparam int CW = $clog2(MIN_ON + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_ON);

    logic [CW-1:0] run_cnt;

    // Count delivered high phases since the last stopped phase.
    always_ff @(negedge clk_src) begin
        if (!rst_n)            run_cnt <= CMAX;
        else if (stopped)      run_cnt <= '0;
        else if (run_cnt != CMAX) run_cnt <= run_cnt + 1'b1;
    end

    // R3
    parked_low_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        stopped |-> (clk_gated == '0));

    // R8
    outputs_equal_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        (clk_gated == '0) || (clk_gated == '1));

    // R6
    free_runs_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        !free_sel |-> clk_free);

    // R7
    free_follows_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        free_sel |-> (clk_free == clk_gated[0]));

    // R4
    min_run_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        $rose(stopped) |-> (run_cnt >= CMAX));

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NUM_GATED(NUM_GATED), .MIN_ON(MIN_ON)) u_chk (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .free_sel  (free_sel),
    .clk_gated (clk_gated),
    .clk_free  (clk_free),
    .stopped   (stopped)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;

    localparam int NG    = 2;
    localparam int SLAT  = 3;
    localparam int RLAT  = 5;
    localparam int MINON = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic          free_sel = 1'b0;
    logic [NG-1:0] clk_gated;
    logic          clk_free;
    logic          stopped;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic pa, pb;
    logic cur_stop_n = 1'b1;

    always #10 clk = ~clk;

    clk_stop_ctrl #(.NUM_GATED(NG), .SYNC_STAGES(2), .STOP_LAT(SLAT),
                    .START_LAT(RLAT), .MIN_ON(MINON)) u_dut (
        .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .free_sel(free_sel),
        .clk_gated(clk_gated), .clk_free(clk_free), .stopped(stopped)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Expected level of the gated output in the i-th high phase after a change.
    function automatic logic exp_pulse(input logic new_stop_n, input int i);
        int lat = new_stop_n ? RLAT : SLAT;
        logic old_lvl = ~new_stop_n;
        return (i <= lat) ? old_lvl : new_stop_n;
    endfunction

    // One clock cycle: sample early and late in the high phase, drive stop_n between.
    task automatic step(input logic sv);
        @(posedge clk);
        #2;
        pa = clk_gated[0];
        chk(clk_gated[1] == clk_gated[0], "R8", clk_gated[1], clk_gated[0]);
        chk(stopped == ~pa, "R9", stopped, ~pa);
        #3;
        stop_n = sv;
        #3;
        pb = clk_gated[0];
        chk(pa == pb, "R3", pb, pa);
        if (free_sel) chk(clk_free == pb, "R7", clk_free, pb);
        else          chk(clk_free == 1'b1, "R6", clk_free, 1);
    endtask

    // Drive a new stop_n level and check the latency edge by edge.
    task automatic transition(input logic sv, input int hold);
        step(sv);
        for (int i = 1; i <= (sv ? RLAT : SLAT) + 4; i++) begin
            step(sv);
            chk(pa == exp_pulse(sv, i), sv ? "R2" : "R1", pa, exp_pulse(sv, i));
        end
        for (int i = 0; i < hold; i++) step(sv);
        cur_stop_n = sv;
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;

        // R10: reset state is running, not stopped
        step(1'b1);
        chk(pa == 1'b1, "R10", pa, 1);
        chk(stopped == 1'b0, "R10", stopped, 0);
        step(1'b1);

        // R10/R1: stop right after reset uses the normal stop latency
        transition(1'b0, 4);

        // R6: companion runs freely while stopped
        free_sel = 1'b0;
        step(1'b0);
        chk(clk_free == 1'b1, "R6", clk_free, 1);
        // R7: companion follows the gate while stopped
        free_sel = 1'b1;
        step(1'b0);
        chk(clk_free == 1'b0, "R7", clk_free, 0);
        free_sel = 1'b0;

        // R5: a release shorter than the restart latency is dropped
        step(1'b1);
        for (int i = 0; i < 12; i++) begin
            step(1'b0);
            chk(pa == 1'b0, "R5", pa, 0);
        end

        // R4: stop requested at the first restarted pulse is held until MIN_ON
        step(1'b1);
        for (int i = 1; i <= RLAT; i++) step(1'b1);
        step(1'b0);
        chk(pa == 1'b1, "R2", pa, 1);
        cnt = 1;
        for (int i = 0; i < 30; i++) begin
            step(1'b0);
            if (pa) cnt++;
        end
        chk(cnt == MINON, "R4", cnt, MINON);
        chk(pa == 1'b0, "R4", pa, 0);
        cur_stop_n = 1'b0;

        // Random phase: alternating requests with random holds and free_sel
        for (int k = 0; k < 16; k++) begin
            free_sel = 1'($urandom % 2);
            transition(~cur_stop_n, 16 + int'($urandom % 20));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule